// File: doc/BRIEF.md
# Universal Pointer Address Decoder

This block turns a 24-bit universal pointer into a memory access. Two pointers are available, each made of three 8-bit general registers of the active register bank. Pointer 0 uses general registers 1, 2 and 3, and pointer 1 uses general registers 5, 6 and 7. In both cases the lowest-numbered register is the most significant byte. A move through a pointer adds a 2-bit offset (0 to 3) to form the effective address and leaves the pointer unchanged. The unit then decodes that address into a target space and a local address.

The 16 MB universal view is laid out as follows. External data starts at the bottom, followed by high data. A single 64 KB page (page 0x7F) holds internal and extended data. Every address with the top bit set is code. Special-function registers have no place in the view. When the extended-mode input is low, only two regions are reachable: the low 64 KB of external data and the low 64 KB of code. Every other address reads as 0x00 and ignores writes.

A separate pointer-add request adds 1 to 4 to the selected pointer. The result appears one clock later on a write-back port, which the register file uses to store the new pointer. Decode outputs are combinational. The write-back port is the only registered path.

Top module: `gptr_unit`

## Requirements
- R1: `sel_i`=0 selects pointer {gpr1_i, gpr2_i, gpr3_i} and `sel_i`=1 selects {gpr5_i, gpr6_i, gpr7_i}, with the first byte named being bits 23:16. The unselected registers have no effect on any output.
- R2: The effective address is (pointer + `ofs_i`) mod 2^24. A carry may cross a page or a space boundary.
- R3: With `ext_mode_i`=1 and effective-address bit 23 set, `space_o`=3 (code) and `local_addr_o` equals effective-address bits 22:0.
- R4: With `ext_mode_i`=1 and effective-address bits 23:16 in 0x00..0x7E, `space_o`=1 (external/high data) and `local_addr_o` equals bits 22:0.
- R5: With `ext_mode_i`=1 and bits 23:16 equal to 0x7F, `space_o`=2 (internal/extended data) and `local_addr_o` holds bits 15:0 zero-extended.
- R6: With `ext_mode_i`=0, page 0x00 gives `space_o`=1 and page 0x80 gives `space_o`=3, each with `local_addr_o` equal to bits 15:0 zero-extended. Every other page gives `space_o`=0 (unreachable) with `local_addr_o`=0.
- R7: In an unreachable space, `rdata_o` is 0x00 and `rd_en_o` is 0. Otherwise `rdata_o` equals `mem_rdata_i` and `rd_en_o` equals `rd_i`.
- R8: A write that decodes to code gives `wr_en_o`=0 and `err_o`=1. A write to an unreachable space gives `wr_en_o`=0 and `err_o`=0. A write to any data space gives `wr_en_o`=1 and `err_o`=0.
- R9: On the clock edge where `inc_i`=1, `wb_valid_o` becomes 1, `wb_sel_o` becomes `sel_i`, and `wb_ptr_o` becomes (pointer + `inc_amt_i` + 1) mod 2^24. On an edge where `inc_i`=0, `wb_valid_o` becomes 0.
- R10: While `rst_ni` is low, `wb_valid_o`, `wb_sel_o` and `wb_ptr_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gpr1_i | input | 8 | Pointer 0 high byte |
| gpr2_i | input | 8 | Pointer 0 middle byte |
| gpr3_i | input | 8 | Pointer 0 low byte |
| gpr5_i | input | 8 | Pointer 1 high byte |
| gpr6_i | input | 8 | Pointer 1 middle byte |
| gpr7_i | input | 8 | Pointer 1 low byte |
| sel_i | input | 1 | Pointer select |
| ofs_i | input | 2 | Access offset 0..3 |
| ext_mode_i | input | 1 | Extended mode (1) or compatibility mode (0) |
| rd_i | input | 1 | Read request |
| wr_i | input | 1 | Write request |
| mem_rdata_i | input | 8 | Data returned by the selected memory |
| inc_i | input | 1 | Pointer-add request |
| inc_amt_i | input | 2 | Add amount minus one |
| space_o | output | 2 | 0 unreachable, 1 external/high, 2 internal/extended, 3 code |
| local_addr_o | output | 23 | Address within the target space |
| rd_en_o | output | 1 | Qualified read |
| wr_en_o | output | 1 | Qualified write |
| err_o | output | 1 | Write to code attempted |
| rdata_o | output | 8 | Read data to the core |
| wb_valid_o | output | 1 | Pointer write-back valid |
| wb_sel_o | output | 1 | Pointer being written back |
| wb_ptr_o | output | 24 | New pointer value |

## Verification
The assertions check on every cycle the rules that hold for any address. No write enable is raised toward code. The error flag appears only for a write decoded as code. An unreachable space returns zero and enables nothing. Compatibility mode never yields a local address above 64 KB. The one-cycle pointer-add result is also checked on every cycle. Only the bench scenarios can show that each page lands in the right space with the right local address. They also cover offset carries across the 0x7E/0x7F/0x80 boundaries, wrap at the top of the view, and the fact that the unselected pointer has no effect.

// File: rtl/gptr_pkg.sv
package gptr_pkg;
  typedef enum logic [1:0] {
    SP_NONE  = 2'd0,
    SP_XDATA = 2'd1,
    SP_IDATA = 2'd2,
    SP_CODE  = 2'd3
  } space_e;
endpackage

// File: rtl/gptr_src_mux.sv
module gptr_src_mux #(
  parameter int NPTR  = 2,
  parameter int PTR_W = 24,
  localparam int SEL_W = (NPTR > 1) ? $clog2(NPTR) : 1
) (
  input  logic [NPTR-1:0][PTR_W-1:0] ptrs_i,
  input  logic [SEL_W-1:0]           sel_i,
  output logic [PTR_W-1:0]           ptr_o
);
  always_comb begin
    ptr_o = '0;
    for (int i = 0; i < NPTR; i++) begin
      if (sel_i == SEL_W'(i)) ptr_o = ptrs_i[i];
    end
  end
endmodule

// File: rtl/gptr_add.sv
module gptr_add #(
  parameter int W   = 24,
  parameter int AMT_W = 3
) (
  input  logic [W-1:0]     base_i,
  input  logic [AMT_W-1:0] amt_i,
  output logic [W-1:0]     sum_o
);
  // modulo 2^W: carry out of the top bit is dropped
  assign sum_o = base_i + W'(amt_i);
endmodule

// File: rtl/gptr_space_dec.sv
module gptr_space_dec
  import gptr_pkg::*;
#(
  parameter int PTR_W      = 24,
  parameter int COMPAT_W   = 16,
  parameter int IDATA_PAGE = 127
) (
  input  logic [PTR_W-1:0] ea_i,
  input  logic             ext_mode_i,
  output space_e           space_o,
  output logic [PTR_W-2:0] local_o
);
  localparam int PAGE_W = PTR_W - COMPAT_W;
  localparam logic [PAGE_W-1:0] PG_IDATA = PAGE_W'(IDATA_PAGE);
  localparam logic [PAGE_W-1:0] PG_CODE0 = {1'b1, {(PAGE_W-1){1'b0}}};

  logic [PAGE_W-1:0]   page;
  logic [PTR_W-2:0]    low_zx;

  assign page   = ea_i[PTR_W-1 -: PAGE_W];
  assign low_zx = (PTR_W-1)'(ea_i[COMPAT_W-1:0]);

  always_comb begin
    space_o = SP_NONE;
    local_o = '0;
    if (ext_mode_i) begin
      if (ea_i[PTR_W-1]) begin
        space_o = SP_CODE;
        local_o = ea_i[PTR_W-2:0];
      end else if (page == PG_IDATA) begin
        space_o = SP_IDATA;
        local_o = low_zx;
      end else begin
        space_o = SP_XDATA;
        local_o = ea_i[PTR_W-2:0];
      end
    end else begin
      // compatibility: only the low window of data and of code
      if (page == '0) begin
        space_o = SP_XDATA;
        local_o = low_zx;
      end else if (page == PG_CODE0) begin
        space_o = SP_CODE;
        local_o = low_zx;
      end
    end
  end
endmodule

// File: rtl/gptr_access.sv
module gptr_access
  import gptr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  space_e            space_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              rd_en_o,
  output logic              wr_en_o,
  output logic              err_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic reach;
  assign reach   = (space_i != SP_NONE);
  assign rd_en_o = rd_i && reach;
  assign wr_en_o = wr_i && reach && (space_i != SP_CODE);
  assign err_o   = wr_i && (space_i == SP_CODE);
  assign rdata_o = reach ? mem_rdata_i : '0;
endmodule

// File: rtl/gptr_unit.sv
module gptr_unit
  import gptr_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int NBYTES     = 3,
  parameter int OFS_W      = 2,
  parameter int INC_W      = 2,
  parameter int COMPAT_W   = 16,
  parameter int IDATA_PAGE = 127,
  localparam int PTR_W     = BYTE_W * NBYTES,
  localparam int NPTR      = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] gpr1_i,
  input  logic [BYTE_W-1:0] gpr2_i,
  input  logic [BYTE_W-1:0] gpr3_i,
  input  logic [BYTE_W-1:0] gpr5_i,
  input  logic [BYTE_W-1:0] gpr6_i,
  input  logic [BYTE_W-1:0] gpr7_i,
  input  logic              sel_i,
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic              ext_mode_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] mem_rdata_i,
  input  logic              inc_i,
  input  logic [INC_W-1:0]  inc_amt_i,
  output logic [1:0]        space_o,
  output logic [PTR_W-2:0]  local_addr_o,
  output logic              rd_en_o,
  output logic              wr_en_o,
  output logic              err_o,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              wb_valid_o,
  output logic              wb_sel_o,
  output logic [PTR_W-1:0]  wb_ptr_o
);
  localparam int STEP_W = INC_W + 1;

  logic [NPTR-1:0][NBYTES-1:0][BYTE_W-1:0] bank;
  logic [NPTR-1:0][PTR_W-1:0]              ptrs;
  logic [PTR_W-1:0]                        ptr;
  logic [PTR_W-1:0]                        ea;
  logic [PTR_W-1:0]                        inc_sum;
  logic [STEP_W-1:0]                       step;
  space_e                                  space;

  // lowest-numbered register is the most significant byte
  assign bank[0] = {gpr1_i, gpr2_i, gpr3_i};
  assign bank[1] = {gpr5_i, gpr6_i, gpr7_i};

  for (genvar p = 0; p < NPTR; p++) begin : g_ptr
    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
      assign ptrs[p][b*BYTE_W +: BYTE_W] = bank[p][b];
    end
  end

  gptr_src_mux #(.NPTR(NPTR), .PTR_W(PTR_W)) u_mux (
    .ptrs_i (ptrs),
    .sel_i  (sel_i),
    .ptr_o  (ptr)
  );

  gptr_add #(.W(PTR_W), .AMT_W(OFS_W)) u_ofs_add (
    .base_i (ptr),
    .amt_i  (ofs_i),
    .sum_o  (ea)
  );

  assign step = STEP_W'(inc_amt_i) + STEP_W'(1);

  gptr_add #(.W(PTR_W), .AMT_W(STEP_W)) u_inc_add (
    .base_i (ptr),
    .amt_i  (step),
    .sum_o  (inc_sum)
  );

  gptr_space_dec #(
    .PTR_W      (PTR_W),
    .COMPAT_W   (COMPAT_W),
    .IDATA_PAGE (IDATA_PAGE)
  ) u_dec (
    .ea_i       (ea),
    .ext_mode_i (ext_mode_i),
    .space_o    (space),
    .local_o    (local_addr_o)
  );

  gptr_access #(.DATA_W(BYTE_W)) u_acc (
    .space_i     (space),
    .rd_i        (rd_i),
    .wr_i        (wr_i),
    .mem_rdata_i (mem_rdata_i),
    .rd_en_o     (rd_en_o),
    .wr_en_o     (wr_en_o),
    .err_o       (err_o),
    .rdata_o     (rdata_o)
  );

  assign space_o = space;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wb_valid_o <= 1'b0;
      wb_sel_o   <= 1'b0;
      wb_ptr_o   <= '0;
    end else begin
      wb_valid_o <= inc_i;
      if (inc_i) begin
        wb_sel_o <= sel_i;
        wb_ptr_o <= inc_sum;
      end
    end
  end
endmodule

// File: rtl/gptr_unit_chk.sv
module gptr_unit_chk #(
  parameter int BYTE_W = 8,
  parameter int INC_W  = 2,
  parameter int PTR_W  = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [BYTE_W-1:0] gpr1_i,
  input logic [BYTE_W-1:0] gpr2_i,
  input logic [BYTE_W-1:0] gpr3_i,
  input logic [BYTE_W-1:0] gpr5_i,
  input logic [BYTE_W-1:0] gpr6_i,
  input logic [BYTE_W-1:0] gpr7_i,
  input logic              sel_i,
  input logic              ext_mode_i,
  input logic              rd_i,
  input logic              wr_i,
  input logic [BYTE_W-1:0] mem_rdata_i,
  input logic              inc_i,
  input logic [INC_W-1:0]  inc_amt_i,
  input logic [1:0]        space_o,
  input logic [PTR_W-2:0]  local_addr_o,
  input logic              rd_en_o,
  input logic              wr_en_o,
  input logic              err_o,
  input logic [BYTE_W-1:0] rdata_o,
  input logic              wb_valid_o,
  input logic              wb_sel_o,
  input logic [PTR_W-1:0]  wb_ptr_o
);
  logic [PTR_W-1:0] ptr_c;
  logic [PTR_W-1:0] next_c;
  assign ptr_c  = sel_i ? {gpr5_i, gpr6_i, gpr7_i} : {gpr1_i, gpr2_i, gpr3_i};
  assign next_c = ptr_c + PTR_W'(inc_amt_i) + PTR_W'(1);

  p_no_code_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (space_o == 2'd3) |-> !wr_en_o);
  p_err_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (wr_i && space_o == 2'd3));
  p_none_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (space_o == 2'd0) |-> (rdata_o == '0 && !rd_en_o && !wr_en_o && !err_o));
  p_rd_pass_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (space_o != 2'd0) |-> (rdata_o == mem_rdata_i && rd_en_o == rd_i));
  p_compat_window_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_mode_i |-> (local_addr_o[PTR_W-2:16] == '0 && space_o != 2'd2));
  p_ext_reach_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_mode_i |-> (space_o != 2'd0));
  p_inc_value_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |=> (wb_valid_o && wb_ptr_o == $past(next_c) && wb_sel_o == $past(sel_i)));
  p_inc_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i |=> !wb_valid_o);
endmodule

bind gptr_unit gptr_unit_chk #(.BYTE_W(BYTE_W), .INC_W(INC_W), .PTR_W(PTR_W)) u_chk (.*);

// File: tb/gptr_unit_test.sv
`timescale 1ns/1ps
module gptr_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  g1 = '0, g2 = '0, g3 = '0, g5 = '0, g6 = '0, g7 = '0;
  logic        sel = 1'b0, mode = 1'b0, rd = 1'b0, wr = 1'b0, inc = 1'b0;
  logic [1:0]  ofs = '0, amt = '0;
  logic [7:0]  mrd = '0;
  logic [1:0]  space;
  logic [22:0] loc;
  logic        rd_en, wr_en, err, wb_valid, wb_sel;
  logic [7:0]  rdata;
  logic [23:0] wb_ptr;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gptr_unit uut (
    .clk_i(clk), .rst_ni(rst_n),
    .gpr1_i(g1), .gpr2_i(g2), .gpr3_i(g3),
    .gpr5_i(g5), .gpr6_i(g6), .gpr7_i(g7),
    .sel_i(sel), .ofs_i(ofs), .ext_mode_i(mode),
    .rd_i(rd), .wr_i(wr), .mem_rdata_i(mrd),
    .inc_i(inc), .inc_amt_i(amt),
    .space_o(space), .local_addr_o(loc),
    .rd_en_o(rd_en), .wr_en_o(wr_en), .err_o(err), .rdata_o(rdata),
    .wb_valid_o(wb_valid), .wb_sel_o(wb_sel), .wb_ptr_o(wb_ptr)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic load_ptr(input logic s, input logic [23:0] p);
    sel = s;
    if (!s) begin
      {g1, g2, g3} = p;  {g5, g6, g7} = ~p;
    end else begin
      {g5, g6, g7} = p;  {g1, g2, g3} = ~p;
    end
  endtask

  // expected decode computed from the requirement text
  task automatic exp_dec(input logic [23:0] ea, input logic m, output logic [1:0] sp, output logic [22:0] lo);
    if (m) begin
      if (ea[23])                 begin sp = 2'd3; lo = ea[22:0]; end
      else if (ea[23:16] == 8'h7F) begin sp = 2'd2; lo = {7'd0, ea[15:0]}; end
      else                        begin sp = 2'd1; lo = ea[22:0]; end
    end else begin
      if (ea[23:16] == 8'h00)      begin sp = 2'd1; lo = {7'd0, ea[15:0]}; end
      else if (ea[23:16] == 8'h80) begin sp = 2'd3; lo = {7'd0, ea[15:0]}; end
      else                        begin sp = 2'd0; lo = '0; end
    end
  endtask

  task automatic access(input logic s, input logic m, input logic [23:0] p, input logic [1:0] o, input int kind);
    logic [23:0] ea;
    logic [1:0]  esp;
    logic [22:0] eloc;
    logic [7:0]  erd;
    logic        erden, ewren, eerr;
    @(negedge clk);
    load_ptr(s, p);
    mode = m; ofs = o;
    rd = (kind == 1); wr = (kind == 2);
    mrd = p[7:0] ^ 8'hA5 ^ {6'd0, o};
    #1;
    ea = p + {22'd0, o};                       // R2: modulo 2^24
    exp_dec(ea, m, esp, eloc);
    erden = rd && (esp != 2'd0);
    ewren = wr && (esp == 2'd1 || esp == 2'd2);
    eerr  = wr && (esp == 2'd3);
    erd   = (esp == 2'd0) ? 8'h00 : mrd;
    // R1 R2 R3 R4 R5 R6: decode of the selected pointer plus offset
    check(space == esp && loc == eloc,
          m ? (esp == 2'd3 ? "R3 code decode" : esp == 2'd2 ? "R5 internal decode" : "R4 data decode (R1/R2)")
            : "R6 compat decode (R1/R2)",
          {39'd0, space, loc}, {39'd0, esp, eloc});
    // R7 R8: access qualification
    check(rd_en == erden && rdata == erd, "R7 read path",
          {55'd0, rd_en, rdata}, {55'd0, erden, erd});
    check(wr_en == ewren && err == eerr, "R8 write path",
          {62'd0, wr_en, err}, {62'd0, ewren, eerr});
  endtask

  task automatic do_inc(input logic s, input logic [23:0] p, input logic [1:0] a);
    logic [23:0] e;
    @(negedge clk);
    load_ptr(s, p);
    inc = 1'b1; amt = a;
    e = p + {21'd0, a} + 24'd1;
    @(negedge clk);
    inc = 1'b0;
    load_ptr(~s, 24'h123456);
    #1;
    check(wb_valid && wb_sel == s && wb_ptr == e, "R9 pointer add result",
          {38'd0, wb_valid, wb_sel, wb_ptr}, {38'd0, 1'b1, s, e});
    @(negedge clk);
    #1;
    check(!wb_valid, "R9 valid drops when idle", {63'd0, wb_valid}, 64'd0);
  endtask

  logic [23:0] bases [16] = '{24'h000000, 24'h00FFFD, 24'h00FFFF, 24'h010000,
                              24'h3A5C7E, 24'h7EFFFE, 24'h7EFFFF, 24'h7F0000,
                              24'h7F00FF, 24'h7FFFFD, 24'h7FFFFF, 24'h800000,
                              24'h80FFFE, 24'h80FFFF, 24'h810000, 24'hFFFFFE};

  initial begin
    logic [23:0] lfsr;
    #12;
    // R10: reset state
    check(!wb_valid && !wb_sel && wb_ptr == '0, "R10 reset state",
          {38'd0, wb_valid, wb_sel, wb_ptr}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int s = 0; s < 2; s++)
      for (int m = 0; m < 2; m++)
        for (int b = 0; b < 16; b++)
          for (int o = 0; o < 4; o++)
            for (int k = 0; k < 3; k++)
              access(s[0], m[0], bases[b], o[1:0], k);
    lfsr = 24'hACE1B5;
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[22:0], lfsr[23] ^ lfsr[22] ^ lfsr[21] ^ lfsr[16]};
      access(lfsr[3], lfsr[9], lfsr, lfsr[5:4], i % 3);
    end
    for (int s = 0; s < 2; s++)
      for (int b = 0; b < 16; b++)
        for (int a = 0; a < 4; a++)
          do_inc(s[0], bases[b], a[1:0]);
    do_inc(1'b1, 24'hFFFFFF, 2'd3);          // R9 wrap to 0x000003
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired act=%h exp=%h", 1'b0, 1'b1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule